// File: doc/BRIEF.md
# Modem Status Register with Change Detection

This block is the modem status register of a byte-wide UART host interface, together with the scratch byte that sits beside it. It samples four modem control pins through a two-flop synchronizer: carrier detect, ring indicate, data set ready and clear to send. The upper nibble of the status byte shows the present level of each pin. The lower nibble holds sticky change flags. Any host read of the status byte clears those flags. When the flags are non-zero and the host has enabled modem-status interrupts, the block raises a level-sensitive interrupt.

In voice mode the data-set-ready bit stops following its pin and tracks DMA activity instead. Entering voice mode drives it high. Each transfer strobe restarts an inactivity timer. The bit drops once the timer runs out, and the timeout length is derived from the clock frequency. A change of the bit caused by voice-mode entry, voice-mode exit or timeout raises its change flag, exactly as a pin change would.

Top module: `modem_status_reg`

## Requirements
- R1: After reset the status byte reads 0x00, the scratch byte reads 0x00 and `irq` is low.
- R2: Status byte bits 7, 6, 5 and 4 show carrier detect, ring indicate, data set ready and clear to send. Each pin change appears in the status byte on the third rising clock edge after it (two synchronizer stages plus the status register).
- R3: Bit 3 (carrier), bit 1 (data set ready) and bit 0 (clear to send) set to 1 on the edge where the matching status bit changes in either direction, and stay set until cleared by a read.
- R4: Bit 2 sets only when the ring bit goes from 1 to 0. A 0-to-1 ring change leaves bit 2 at 0.
- R5: A read of offset 6 returns the status byte as it was before the read, and then clears bits 3:0. A change detected on the same edge as the read leaves its flag at 1.
- R6: `irq` equals `msi_en` AND (any of bits 3:0 set), with no added latency. It falls as soon as the flags are cleared or `msi_en` goes low.
- R7: Offset 7 is a read/write scratch byte. A read of any offset other than 6 or 7 returns 0x00.
- R8: When `voice_mode` rises, data set ready goes to 1 on the next edge, whatever its pin shows. The pin is ignored while in voice mode and followed again after voice mode is left.
- R9: In voice mode each `dma_xfer` strobe restarts a timeout of CLK_KHZ*TIMEOUT_US/1000 cycles. If that many cycles pass without a strobe, data set ready drops to 0 and bit 1 sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dcd_pin | input | 1 | Carrier detect pin, asynchronous |
| ri_pin | input | 1 | Ring indicate pin, asynchronous |
| dsr_pin | input | 1 | Data set ready pin, asynchronous |
| cts_pin | input | 1 | Clear to send pin, asynchronous |
| voice_mode | input | 1 | Voice mode active, synchronous |
| dma_xfer | input | 1 | One-cycle DMA transfer strobe |
| msi_en | input | 1 | Modem-status interrupt enable |
| host_addr | input | 3 | Register offset |
| host_rd | input | 1 | Read strobe, one cycle per read |
| host_wr | input | 1 | Write strobe |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, combinational from the addressed register |
| irq | output | 1 | Modem-status interrupt, level |

## Verification
The hardest case to reach is a host read that lands on the same edge where a synchronized pin change reaches the status register. The read must return the old byte, and the new flag must survive the clear. The bench changes clear-to-send on a falling edge and counts exactly two more falling edges, so the read strobe covers the third rising edge. It then reads again to see the surviving flag. The DMA timeout is shortened by parameter, so the bench can place reads a few cycles before and after expiry.

// File: rtl/msr_pkg.sv
package msr_pkg;

  localparam logic [2:0] MSR_OFS = 3'd6;
  localparam logic [2:0] SCR_OFS = 3'd7;

  typedef struct packed {
    logic dcd;
    logic ri;
    logic dsr;
    logic cts;
  } mstat_t;

  // Cycles in the inactivity window; never less than one.
  function automatic int calc_timeout_cycles(input int clk_khz, input int tout_us);
    int c;
    c = (clk_khz * tout_us) / 1000;
    if (c < 1) c = 1;
    return c;
  endfunction

  // Change events in flag order {carrier, ring trailing, dsr, cts}.
  function automatic logic [3:0] change_events(input mstat_t cur, input mstat_t nxt);
    logic [3:0] ev;
    ev[3] = cur.dcd ^ nxt.dcd;
    ev[2] = cur.ri & ~nxt.ri;
    ev[1] = cur.dsr ^ nxt.dsr;
    ev[0] = cur.cts ^ nxt.cts;
    return ev;
  endfunction

  // Sticky flags: read clears, a same-cycle event wins over the clear.
  function automatic logic [3:0] next_flags(input logic [3:0] old, input logic [3:0] ev,
                                            input logic rd_clr);
    logic [3:0] kept;
    kept = rd_clr ? 4'b0000 : old;
    return kept | ev;
  endfunction

endpackage

// File: rtl/msr_sync.sv
module msr_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;
  logic [W-1:0] stage2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= d;
      stage2 <= stage1;
    end
  end

  assign q = stage2;
endmodule

// File: rtl/msr_dsr_timer.sv
module msr_dsr_timer #(
  parameter int LOAD  = 17,
  parameter int CNT_W = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic voice_mode,
  input  logic dma_xfer,
  output logic voice_active,
  output logic dsr_hold,
  output logic entry_evt
);
  localparam logic [CNT_W-1:0] LOAD_V = CNT_W'(LOAD);

  logic [CNT_W-1:0] cnt_q;
  logic             voice_q;
  logic             reload;

  assign entry_evt = voice_mode & ~voice_q;
  assign reload    = entry_evt | dma_xfer;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      voice_q <= 1'b0;
    end else begin
      voice_q <= voice_mode;
      if (!voice_mode)
        cnt_q <= '0;
      else if (reload)
        cnt_q <= LOAD_V;
      else if (cnt_q != '0)
        cnt_q <= cnt_q - 1'b1;
    end
  end

  assign voice_active = voice_q;
  assign dsr_hold     = (cnt_q != '0);

  // R8: entering voice mode holds DSR high on the next edge
  a_r8_entry_hold: assert property (@(posedge clk) disable iff (!rst_n)
    entry_evt |=> dsr_hold);

  // R9: a transfer strobe reloads the full window
  a_r9_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (voice_mode && dma_xfer) |=> (cnt_q == LOAD_V));

  // R9: the counter never exceeds its window
  a_r9_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LOAD_V);

  // R8: leaving voice mode releases the hold
  a_r8_exit_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !voice_mode |=> !dsr_hold);
endmodule

// File: rtl/msr_delta.sv
module msr_delta
  import msr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  mstat_t     eff,
  input  logic       rd_clr,
  output mstat_t     stat_q,
  output logic [3:0] flag_q,
  output logic [3:0] set_ev
);
  assign set_ev = change_events(stat_q, eff);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= '0;
      flag_q <= '0;
    end else begin
      stat_q <= eff;
      flag_q <= next_flags(flag_q, set_ev, rd_clr);
    end
  end

  for (genvar i = 0; i < 4; i++) begin : g_flag_chk
    // R3: a detected change leaves its flag set
    a_r3_set: assert property (@(posedge clk) disable iff (!rst_n)
      set_ev[i] |=> flag_q[i]);
    // R5: a read without a coincident event clears the flag
    a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_clr && !set_ev[i]) |=> !flag_q[i]);
  end

  // R4: trailing ring flag only appears when the ring level falls
  a_r4_trailing: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q[2]) |-> $fell(stat_q.ri));
endmodule

// File: rtl/modem_status_reg.sv
module modem_status_reg
  import msr_pkg::*;
#(
  parameter int CLK_KHZ    = 125000,
  parameter int TIMEOUT_US = 1700
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dcd_pin,
  input  logic       ri_pin,
  input  logic       dsr_pin,
  input  logic       cts_pin,
  input  logic       voice_mode,
  input  logic       dma_xfer,
  input  logic       msi_en,
  input  logic [2:0] host_addr,
  input  logic       host_rd,
  input  logic       host_wr,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  output logic       irq
);
  localparam int TOUT_CYC = calc_timeout_cycles(CLK_KHZ, TIMEOUT_US);
  localparam int CNT_W    = $clog2(TOUT_CYC + 1);

  logic [3:0] pin_sync;
  logic       voice_active;
  logic       dsr_hold;
  logic       entry_evt;
  mstat_t     eff;
  mstat_t     stat_q;
  logic [3:0] flag_q;
  logic [3:0] set_ev;
  logic       msr_read;
  logic       scr_write;
  logic [7:0] scratch_q;

  msr_sync #(.W(4)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({dcd_pin, ri_pin, dsr_pin, cts_pin}),
    .q     (pin_sync)
  );

  msr_dsr_timer #(.LOAD(TOUT_CYC), .CNT_W(CNT_W)) u_timer (
    .clk          (clk),
    .rst_n        (rst_n),
    .voice_mode   (voice_mode),
    .dma_xfer     (dma_xfer),
    .voice_active (voice_active),
    .dsr_hold     (dsr_hold),
    .entry_evt    (entry_evt)
  );

  always_comb begin
    eff.dcd = pin_sync[3];
    eff.ri  = pin_sync[2];
    eff.dsr = voice_active ? dsr_hold : pin_sync[1];
    eff.cts = pin_sync[0];
  end

  assign msr_read  = host_rd && (host_addr == MSR_OFS);
  assign scr_write = host_wr && (host_addr == SCR_OFS);

  msr_delta u_delta (
    .clk    (clk),
    .rst_n  (rst_n),
    .eff    (eff),
    .rd_clr (msr_read),
    .stat_q (stat_q),
    .flag_q (flag_q),
    .set_ev (set_ev)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)
      scratch_q <= '0;
    else if (scr_write)
      scratch_q <= host_wdata;
  end

  always_comb begin
    case (host_addr)
      MSR_OFS: host_rdata = {stat_q, flag_q};
      SCR_OFS: host_rdata = scratch_q;
      default: host_rdata = '0;
    endcase
  end

  assign irq = msi_en & (|flag_q);

  // R6: interrupt only falls on a read or a disable
  a_r6_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> (!msi_en || $past(msr_read)));

  // R7: scratch write lands on the next edge
  a_r7_scratch: assert property (@(posedge clk) disable iff (!rst_n)
    scr_write |=> (scratch_q == $past(host_wdata)));

  // R8: in voice mode the status DSR follows the hold, one edge later
  a_r8_voice_dsr: assert property (@(posedge clk) disable iff (!rst_n)
    voice_active |=> (stat_q.dsr == $past(dsr_hold)));
endmodule

// File: tb/modem_status_reg_bench.sv
module modem_status_reg_bench;
  localparam int CLK_KHZ = 10;
  localparam int TOUT_US = 1700;
  localparam int T       = CLK_KHZ * TOUT_US / 1000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dcd_pin = 0, ri_pin = 0, dsr_pin = 0, cts_pin = 0;
  logic       voice_mode = 0, dma_xfer = 0, msi_en = 1;
  logic [2:0] host_addr = 3'd0;
  logic       host_rd = 0, host_wr = 0;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata;
  logic       irq;

  int checks = 0;
  int errors = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  event       rd_ev;

  always #4 clk = ~clk;

  modem_status_reg #(.CLK_KHZ(CLK_KHZ), .TIMEOUT_US(TOUT_US)) u_modem_status_reg (
    .clk(clk), .rst_n(rst_n),
    .dcd_pin(dcd_pin), .ri_pin(ri_pin), .dsr_pin(dsr_pin), .cts_pin(cts_pin),
    .voice_mode(voice_mode), .dma_xfer(dma_xfer), .msi_en(msi_en),
    .host_addr(host_addr), .host_rd(host_rd), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .irq(irq)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // Driver: pushes the expectation, then issues a one-cycle read.
  task automatic do_read(input logic [2:0] a, input logic [7:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    host_addr = a;
    host_rd   = 1'b1;
    ->rd_ev;
    @(negedge clk);
    host_rd   = 1'b0;
  endtask

  task automatic do_write(input logic [2:0] a, input logic [7:0] d);
    host_addr  = a;
    host_wdata = d;
    host_wr    = 1'b1;
    @(negedge clk);
    host_wr    = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  // Monitor: compares read data against the scoreboard queue.
  initial begin
    forever begin
      @(rd_ev);
      #1;
      check(tag_q.pop_front(), host_rdata, exp_q.pop_front());
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    do_read(3'd6, 8'h00, "R1 status after reset");
    do_read(3'd7, 8'h00, "R1 scratch after reset");
    check("R1 irq after reset", {7'd0, irq}, 8'h00);

    // R7 scratch and unmapped offset
    do_write(3'd7, 8'hA5);
    do_read(3'd7, 8'hA5, "R7 scratch readback");
    do_read(3'd2, 8'h00, "R7 unmapped offset");

    // R2 R3 R6 clear to send rises
    cts_pin = 1'b1;
    settle();
    check("R6 irq on flag", {7'd0, irq}, 8'h01);
    do_read(3'd6, 8'h11, "R3 cts rise flag");
    do_read(3'd6, 8'h10, "R5 read clears flag");
    check("R6 irq after clear", {7'd0, irq}, 8'h00);

    // R2 R3 carrier
    dcd_pin = 1'b1;
    settle();
    do_read(3'd6, 8'h98, "R3 carrier rise flag");
    do_read(3'd6, 8'h90, "R5 carrier cleared");

    // R4 ring rise then fall
    ri_pin = 1'b1;
    settle();
    do_read(3'd6, 8'hD0, "R4 ring rise sets no flag");
    check("R4 irq quiet on ring rise", {7'd0, irq}, 8'h00);
    ri_pin = 1'b0;
    settle();
    do_read(3'd6, 8'h94, "R4 ring fall sets trailing flag");
    do_read(3'd6, 8'h90, "R5 trailing cleared");

    // R2 R3 data set ready pin
    dsr_pin = 1'b1;
    settle();
    do_read(3'd6, 8'hB2, "R3 dsr rise flag");
    do_read(3'd6, 8'hB0, "R5 dsr cleared");

    // R6 enable gating, level behaviour
    msi_en  = 1'b0;
    cts_pin = 1'b0;
    settle();
    check("R6 irq masked", {7'd0, irq}, 8'h00);
    msi_en = 1'b1;
    @(negedge clk);
    check("R6 irq on enable", {7'd0, irq}, 8'h01);
    do_read(3'd6, 8'hA1, "R3 cts fall flag");

    // R2 three-edge latency and R5 read coincident with event
    cts_pin = 1'b1;
    @(negedge clk);
    @(negedge clk);
    do_read(3'd6, 8'hA0, "R5 coincident read sees old byte");
    do_read(3'd6, 8'hB1, "R5 coincident flag survives");
    do_read(3'd6, 8'hB0, "R5 flag cleared afterwards");

    // R8 voice entry forces DSR
    dsr_pin = 1'b0;
    settle();
    do_read(3'd6, 8'h92, "R3 dsr fall flag");
    voice_mode = 1'b1;
    settle();
    do_read(3'd6, 8'hB2, "R8 voice entry raises dsr");
    dsr_pin = 1'b1;
    settle();
    do_read(3'd6, 8'hB0, "R8 pin ignored in voice mode");

    // R9 strobes keep DSR high, timeout drops it
    for (int k = 0; k < 4; k++) begin
      dma_xfer = 1'b1;
      @(negedge clk);
      dma_xfer = 1'b0;
      repeat (T / 2) @(negedge clk);
    end
    dma_xfer = 1'b1;
    @(negedge clk);
    dma_xfer = 1'b0;
    repeat (T - 3) @(negedge clk);
    do_read(3'd6, 8'hB0, "R9 dsr held before timeout");
    repeat (6) @(negedge clk);
    check("R9 irq on timeout", {7'd0, irq}, 8'h01);
    do_read(3'd6, 8'h92, "R9 dsr dropped after timeout");

    // R8 leaving voice mode returns to the pin
    voice_mode = 1'b0;
    settle();
    do_read(3'd6, 8'hB2, "R8 exit follows pin");

    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule